// File: doc/BRIEF.md
# External Trigger Input Conditioner

This block turns a raw external trigger pin into a clean counting clock for a timer counter. The pin is brought into the internal clock domain through a two-stage synchronizer. A polarity bit can invert it. An edge prescaler can then reduce the edge rate by 1, 2, 4 or 8. A digital filter follows, and it is sampled only on cycles where a sampling-clock enable is high. Every rising edge of the conditioned level advances the counter by one.

A dedicated mode-enable bit selects the conditioned pin as the counter's clock source. This bit is separate from any slave-mode selection. A second, lower-priority source stands in for the trigger-input clock mode: it is a one-cycle tick with its own enable. When both enables are set, the conditioned pin wins.

Top module: `etr_conditioner`

## Requirements
- R1: Asynchronous active-low reset clears the counter, the synchronizer, the prescaler and the filter. After reset, with the pin low and inversion off, `condOut` is 0 and `count` is 0.
- R2: The pin passes through two synchronizer flops. With `prescSel`=00 and `filtLen`=0, a pin level sampled at clock edge k appears on `condOut` after edge k+1, and the counter reflects its rising edge after edge k+2.
- R3: With `invertPol`=1 the pin is inverted before the prescaler, so falling edges of the pin are the ones counted.
- R4: The `prescSel` code picks the division: 00 counts every rising edge, 01 every 2nd, 10 every 4th, 11 every 8th. For the divided codes, the prescaled level toggles once per 2^(code-1) rising edges.
- R5: `filtLen`=0 bypasses the filter. For a nonzero N, the filtered level takes a new value only after N consecutive samples that differ from it, so a shorter disagreement is discarded.
- R6: The filter samples only on cycles with `sampleEn`=1. With a nonzero `filtLen`, its state is frozen on all other cycles.
- R7: With `modeEn`=1, `count` increases by exactly one for each rising edge of `condOut`, and never by more than one per cycle. It wraps modulo 2^CNT_W.
- R8: With `modeEn`=1, `altTick` has no effect on `count`, even when `altEn`=1.
- R9: With `modeEn`=0 and `altEn`=1, `count` increases by one for each cycle in which `altTick` is high, and the pin has no effect.
- R10: With `modeEn`=0 and `altEn`=0, `count` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trigPin | input | 1 | Raw external trigger pin, asynchronous |
| sampleEn | input | 1 | Sampling-clock enable for the filter |
| modeEn | input | 1 | Selects the conditioned pin as the counter clock |
| invertPol | input | 1 | 1 inverts the pin, so falling edges are counted |
| prescSel | input | 2 | Edge divider code: 00 /1, 01 /2, 10 /4, 11 /8 |
| filtLen | input | 4 | Filter length in samples; 0 means bypass |
| altEn | input | 1 | Enables the lower-priority tick source |
| altTick | input | 1 | One-cycle count request from the lower-priority source |
| condOut | output | 1 | Conditioned trigger level |
| count | output | CNT_W | Counter value |

## Verification
The hardest case to reach is the filter working with a sparse sampling enable. Pulses must be long enough to span several sampling cycles yet still be rejected, or accepted only on the exact sampling cycle. The bench drives the sampling enable as one cycle in four and sends both short pulses (under one sample period) and long pulses (three sample periods) at a filter length of two. A cycle-accurate behavioural model tracks every clock, so an off-by-one slip in the sampling count shows up as a one-cycle mismatch on `condOut`. Prescaler phases use bursts of sixteen pulses, so each division code yields a distinct count delta.

// File: rtl/etr_pkg.sv
package etr_pkg;
  typedef struct packed {
    logic polLevel;    // synchronized, polarity-adjusted pin level
    logic presStep;    // one-cycle strobe on a rising edge of polLevel
    logic filtSample;  // filter sampling strobe
    logic cntInc;      // counter advance strobe
  } etrStrobe_t;
endpackage

// File: rtl/etr_ctrl.sv
module etr_ctrl
  import etr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       trigPin,
  input  logic       invertPol,
  input  logic       sampleEn,
  input  logic       modeEn,
  input  logic       altEn,
  input  logic       altTick,
  input  logic       condLevel,
  output etrStrobe_t strobes
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic polLevel;
  logic polPrev;
  logic condPrev;
  logic condRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '0;
      polPrev  <= 1'b0;
      condPrev <= 1'b0;
    end else begin
      syncQ    <= {syncQ[SYNC_STAGES-2:0], trigPin};
      polPrev  <= polLevel;
      condPrev <= condLevel;
    end
  end

  assign polLevel = syncQ[SYNC_STAGES-1] ^ invertPol;
  assign condRise = condLevel & ~condPrev;

  always_comb begin
    strobes.polLevel   = polLevel;
    strobes.presStep   = polLevel & ~polPrev;
    strobes.filtSample = sampleEn;
    // the conditioned pin takes priority over the alternate tick source
    strobes.cntInc     = modeEn ? condRise : (altEn & altTick);
  end
endmodule

// File: rtl/etr_datapath.sv
module etr_datapath
  import etr_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PRESC_W = 2,
  parameter int FILT_W  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  etrStrobe_t         strobes,
  input  logic [PRESC_W-1:0] prescSel,
  input  logic [FILT_W-1:0]  filtLen,
  output logic               condLevel,
  output logic [CNT_W-1:0]   count
);
  localparam int MAX_LOG   = (1 << PRESC_W) - 1;
  localparam int DIV_CNT_W = (MAX_LOG > 1) ? MAX_LOG - 1 : 1;

  logic [DIV_CNT_W-1:0] divCnt;
  logic [DIV_CNT_W-1:0] divLast;
  logic                 presTog;
  logic                 presLevel;
  logic [FILT_W-1:0]    fCnt;
  logic                 filtReg;

  // prescaler: toggle every 2^(code-1) steps, straight through for code 0
  always_comb begin
    if (prescSel == '0) divLast = '0;
    else                divLast = DIV_CNT_W'((1 << (prescSel - 1'b1)) - 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      presTog <= 1'b0;
    end else if (strobes.presStep && prescSel != '0) begin
      if (divCnt >= divLast) begin
        divCnt  <= '0;
        presTog <= ~presTog;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign presLevel = (prescSel == '0) ? strobes.polLevel : presTog;

  // filter: N consecutive disagreeing samples move the output
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fCnt    <= '0;
      filtReg <= 1'b0;
    end else if (filtLen == '0) begin
      fCnt    <= '0;
      filtReg <= presLevel;
    end else if (strobes.filtSample) begin
      if (presLevel != filtReg) begin
        if (fCnt + 1'b1 == filtLen) begin
          fCnt    <= '0;
          filtReg <= presLevel;
        end else begin
          fCnt <= fCnt + 1'b1;
        end
      end else begin
        fCnt <= '0;
      end
    end
  end

  assign condLevel = (filtLen == '0) ? presLevel : filtReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               count <= '0;
    else if (strobes.cntInc) count <= count + 1'b1;
  end

  assert_presc_step_only_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(presTog) |-> ($past(strobes.presStep) && $past(prescSel) != '0));

  assert_filter_run_length_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(filtReg) && $past(filtLen) != '0) |-> ($past(fCnt) + 1'b1 == $past(filtLen)));

  assert_filter_frozen_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(filtLen) != '0 && !$past(strobes.filtSample)) |-> ($stable(filtReg) && $stable(fCnt)));

  assert_single_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    (count == $past(count)) || (count == $past(count) + 1'b1));
endmodule

// File: rtl/etr_conditioner.sv
module etr_conditioner
  import etr_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRESC_W     = 2,
  parameter int FILT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trigPin,
  input  logic               sampleEn,
  input  logic               modeEn,
  input  logic               invertPol,
  input  logic [PRESC_W-1:0] prescSel,
  input  logic [FILT_W-1:0]  filtLen,
  input  logic               altEn,
  input  logic               altTick,
  output logic               condOut,
  output logic [CNT_W-1:0]   count
);
  etrStrobe_t strobes;
  logic       condLevel;

  etr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .trigPin(trigPin), .invertPol(invertPol),
    .sampleEn(sampleEn), .modeEn(modeEn), .altEn(altEn), .altTick(altTick),
    .condLevel(condLevel), .strobes(strobes)
  );

  etr_datapath #(.CNT_W(CNT_W), .PRESC_W(PRESC_W), .FILT_W(FILT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .prescSel(prescSel),
    .filtLen(filtLen), .condLevel(condLevel), .count(count)
  );

  assign condOut = condLevel;

  assert_no_source_holds_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!modeEn && !altEn) |=> (count == $past(count)));

  assert_alt_masked_R8: assert property (@(posedge clk) disable iff (!rstN)
    (modeEn && !condLevel) |=> (count == $past(count)));
endmodule

// File: tb/etr_conditioner_tb.sv
module etr_conditioner_tb;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trigPin = 1'b0, sampleEn = 1'b1, modeEn = 1'b1, invertPol = 1'b0;
  logic [1:0] prescSel = 2'd0;
  logic [3:0] filtLen = 4'd0;
  logic altEn = 1'b0, altTick = 1'b0;
  logic condOut;
  logic [CNT_W-1:0] count;

  int checks = 0, fails = 0;
  int sampDiv = 1, cyc = 0;
  string curReq = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  etr_conditioner #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .trigPin(trigPin), .sampleEn(sampleEn),
    .modeEn(modeEn), .invertPol(invertPol), .prescSel(prescSel),
    .filtLen(filtLen), .altEn(altEn), .altTick(altTick),
    .condOut(condOut), .count(count)
  );

  // behavioural reference
  int m1 = 0, m2 = 0, mPolPrev = 0, mPresCnt = 0, mPresOut = 0;
  int mFCnt = 0, mFReg = 0, mFPrev = 0, mCnt = 0;

  function automatic int mPol();
    return m2 ^ int'(invertPol);
  endfunction
  function automatic int mPres();
    return (prescSel == 0) ? mPol() : mPresOut;
  endfunction
  function automatic int mCond();
    return (filtLen == 0) ? mPres() : mFReg;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      m1 = 0; m2 = 0; mPolPrev = 0; mPresCnt = 0; mPresOut = 0;
      mFCnt = 0; mFReg = 0; mFPrev = 0; mCnt = 0;
    end else begin
      int pol, pres, cond, src;
      pol  = mPol();
      pres = mPres();
      cond = mCond();
      if (modeEn)     src = (cond == 1 && mFPrev == 0) ? 1 : 0;
      else if (altEn) src = int'(altTick);
      else            src = 0;
      if (pol == 1 && mPolPrev == 0 && prescSel != 0) begin
        if (mPresCnt + 1 >= (1 << (int'(prescSel) - 1))) begin
          mPresOut = 1 - mPresOut; mPresCnt = 0;
        end else mPresCnt++;
      end
      if (filtLen == 0) begin
        mFReg = pres; mFCnt = 0;
      end else if (sampleEn) begin
        if (pres != mFReg) begin
          if (mFCnt + 1 == int'(filtLen)) begin mFReg = pres; mFCnt = 0; end
          else mFCnt++;
        end else mFCnt = 0;
      end
      mFPrev = cond; mPolPrev = pol; m2 = m1; m1 = int'(trigPin);
      if (src == 1) mCnt = (mCnt + 1) % (1 << CNT_W);
    end
  end

  // per-clock comparison, away from the active edge
  always @(posedge clk) begin
    #5;
    if (rstN && !done) begin
      checks++;
      if (int'(count) != mCnt || int'(condOut) != mCond()) begin
        fails++;
        $display("FAIL %s: count=%0d condOut=%0d expected count=%0d condOut=%0d",
                 curReq, count, condOut, mCnt, mCond());
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    sampleEn = (cyc % sampDiv) == 0;
  end

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(int hi, int lo, int n);
    for (int i = 0; i < n; i++) begin
      trigPin = 1'b1; waitCycles(hi);
      trigPin = 1'b0; waitCycles(lo);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; waitCycles(2); rstN = 1'b1; waitCycles(6);
  endtask

  task automatic checkDelta(string req, int startVal, int exp);
    int got;
    got = int'(count) - startVal;
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: count delta=%0d expected %0d", req, got, exp);
    end
  endtask

  initial begin
    int s;
    @(negedge clk); @(negedge clk);
    // R1: reset state
    checks++;
    if (count != '0 || condOut != 1'b0) begin
      fails++;
      $display("FAIL R1: count=%0d condOut=%0d expected 0 0", count, condOut);
    end
    doReset();

    // R2 / R7: straight path, each pin pulse counted once
    curReq = "R2"; s = int'(count);
    pulses(3, 3, 5); waitCycles(6);
    checkDelta("R2", s, 5);
    curReq = "R7"; s = int'(count);
    pulses(1, 1, 7); waitCycles(6);
    checkDelta("R7", s, 7);

    // R3: inverted polarity counts falling edges
    curReq = "R3"; invertPol = 1'b1; doReset(); s = int'(count);
    pulses(3, 3, 5); waitCycles(6);
    checkDelta("R3", s, 5);
    invertPol = 1'b0;

    // R4: division codes
    for (int code = 1; code < 4; code++) begin
      curReq = "R4"; prescSel = 2'(code); doReset(); s = int'(count);
      pulses(2, 2, 16); waitCycles(8);
      checkDelta("R4", s, 16 >> code);
    end
    prescSel = 2'd0;

    // R5: filter length 3, every cycle sampled
    curReq = "R5"; filtLen = 4'd3; doReset(); s = int'(count);
    pulses(2, 6, 4); waitCycles(10);
    checkDelta("R5", s, 0);
    s = int'(count);
    pulses(6, 6, 4); waitCycles(10);
    checkDelta("R5", s, 4);

    // R6: filter length 2, sampled one cycle in four
    curReq = "R6"; filtLen = 4'd2; sampDiv = 4; doReset(); s = int'(count);
    pulses(3, 13, 4); waitCycles(20);
    checkDelta("R6", s, 0);
    s = int'(count);
    pulses(12, 12, 3); waitCycles(20);
    checkDelta("R6", s, 3);
    filtLen = 4'd0; sampDiv = 1;

    // R8: alternate ticks ignored while the pin source is selected
    curReq = "R8"; altEn = 1'b1; doReset(); s = int'(count);
    for (int i = 0; i < 6; i++) begin altTick = 1'b1; waitCycles(1); altTick = 1'b0; waitCycles(2); end
    waitCycles(4);
    checkDelta("R8", s, 0);

    // R9: alternate source counts its ticks, pin ignored
    curReq = "R9"; modeEn = 1'b0; s = int'(count);
    for (int i = 0; i < 7; i++) begin
      altTick = 1'b1; trigPin = 1'b1; waitCycles(1);
      altTick = 1'b0; trigPin = 1'b0; waitCycles(2);
    end
    waitCycles(6);
    checkDelta("R9", s, 7);

    // R10: no source, nothing counts
    curReq = "R10"; altEn = 1'b0; s = int'(count);
    for (int i = 0; i < 5; i++) begin
      altTick = 1'b1; trigPin = 1'b1; waitCycles(2);
      altTick = 1'b0; trigPin = 1'b0; waitCycles(2);
    end
    waitCycles(6);
    checkDelta("R10", s, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule